// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This block resolves read-after-write conflicts in a five-stage in-order integer pipeline: fetch, decode, execute, memory and writeback. Every instruction visits all five stages. Operands are read in decode and results are written only in writeback. Because those stages are fixed, write-after-read and write-after-write conflicts cannot arise, and only read-after-write needs handling.

For the instruction in execute, the block compares each source register number with the destinations held in the execute/memory and memory/writeback buffers. From that comparison it drives a 2-bit select for each ALU operand multiplexer. When both buffers match, the younger result, the one in execute/memory, takes precedence.

A load that is immediately followed by a consumer of its destination cannot be covered by forwarding. For that case the block raises a stall. The surrounding pipeline uses the stall to hold the PC and the fetch/decode buffer, and to send an idle bubble into execute.

The block also contains the register file. A write from writeback is visible to a decode read in the same cycle, so results in writeback need no forwarding path of their own.

Top module: `fwd_hazard_ctl`

## Requirements
- R1: The operand select takes only the values 2'b00 (register file value), 2'b01 (forward from memory/writeback) and 2'b10 (forward from execute/memory). It is 2'b10 when the execute source is nonzero and equals the execute/memory destination, that entry writes, and that entry is not a load.
- R2: The select is 2'b01 when the execute source is nonzero, the memory/writeback entry writes to it, and R1 does not apply.
- R3: When both buffers qualify for the same source, the select is 2'b10.
- R4: A source of register 0 always gives select 2'b00.
- R5: An execute/memory entry flagged as a load is never a forwarding source. Its source falls back to the memory/writeback entry or to the register file.
- R6: The stall is 1 when all of the following hold: the execute instruction is a load, its destination is nonzero, and that destination equals a decode source whose use flag is set.
- R7: The stall is 0 in every other case. This covers an unused matching source, a load destination of 0, and a non-load in execute.
- R8: A decode read of the register being written back in the same cycle returns the write data.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: Synchronous reset clears every register to zero.
- R11: A written value persists across later cycles. A cycle with the write enable low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs_a | input | AW | Decode instruction, first source number |
| id_rs_b | input | AW | Decode instruction, second source number |
| id_use_a | input | 1 | Decode instruction actually reads first source |
| id_use_b | input | 1 | Decode instruction actually reads second source |
| ex_rs_a | input | AW | Execute instruction, first source number |
| ex_rs_b | input | AW | Execute instruction, second source number |
| ex_rd | input | AW | Execute instruction destination |
| ex_is_load | input | 1 | Execute instruction is a load |
| xm_rd | input | AW | Execute/memory buffer destination |
| xm_we | input | 1 | Execute/memory buffer writes a register |
| xm_load | input | 1 | Execute/memory buffer holds a load |
| mw_rd | input | AW | Memory/writeback buffer destination |
| mw_we | input | 1 | Memory/writeback buffer writes a register |
| mw_wdata | input | DW | Writeback data |
| fwd_sel_a | output | 2 | First ALU operand select |
| fwd_sel_b | output | 2 | Second ALU operand select |
| stall | output | 1 | Hold PC and fetch/decode, bubble into execute |
| id_rdata_a | output | DW | Register file value for first decode source |
| id_rdata_b | output | DW | Register file value for second decode source |

## Verification
The bench builds the block with AW=3 and DW=8. With eight registers, every combination of source, both buffer destinations, their write enables and the load flag can be swept in full. That includes the register-0 cases and the double-match cases. The load-interlock sweep likewise covers every pairing of load destination, both decode sources and both use flags. The eight-entry file also lets every register be written, bypass-read in the same cycle and read back afterwards.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    typedef enum logic [1:0] {
        SEL_RF = 2'b00,
        SEL_MW = 2'b01,
        SEL_XM = 2'b10
    } opsel_e;

    // Younger result wins: the execute/memory hit is tested first.
    function automatic opsel_e pick_src(input logic src_nz,
                                        input logic xm_hit,
                                        input logic mw_hit);
        if (!src_nz)     return SEL_RF;
        else if (xm_hit) return SEL_XM;
        else if (mw_hit) return SEL_MW;
        else             return SEL_RF;
    endfunction

endpackage

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
    import hzd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] xm_rd,
    input  logic          xm_we,
    input  logic          xm_load,
    input  logic [AW-1:0] mw_rd,
    input  logic          mw_we,
    output opsel_e        sel
);
    logic src_nz;
    logic xm_hit;
    logic mw_hit;

    assign src_nz = (src != '0);
    // A load in execute/memory has no data yet, so it cannot forward.
    assign xm_hit = xm_we && !xm_load && (xm_rd == src);
    assign mw_hit = mw_we && (mw_rd == src);
    assign sel    = pick_src(src_nz, xm_hit, mw_hit);
endmodule

// File: rtl/hzd_load_lock.sv
module hzd_load_lock #(
    parameter int AW = 5
) (
    input  logic          ex_is_load,
    input  logic [AW-1:0] ex_rd,
    input  logic [AW-1:0] id_rs_a,
    input  logic [AW-1:0] id_rs_b,
    input  logic          id_use_a,
    input  logic          id_use_b,
    output logic          stall
);
    logic dst_nz;
    logic hit_a;
    logic hit_b;

    assign dst_nz = (ex_rd != '0);
    assign hit_a  = id_use_a && (id_rs_a == ex_rd);
    assign hit_b  = id_use_b && (id_rs_b == ex_rd);
    assign stall  = ex_is_load && dst_nz && (hit_a || hit_b);
endmodule

// File: rtl/hzd_regfile.sv
module hzd_regfile #(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b
);
    localparam int NREG = 1 << AW;

    logic [DW-1:0] regs [NREG];

    // Entry 0 stays zero; writes to it are dropped.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // Write-first read: a same-cycle write is seen by decode.
    function automatic logic [DW-1:0] rd_port(input logic [AW-1:0] ra,
                                              input logic          w_en,
                                              input logic [AW-1:0] w_a,
                                              input logic [DW-1:0] w_d,
                                              input logic [DW-1:0] stored);
        if (ra == '0)                  return '0;
        else if (w_en && (w_a == ra))  return w_d;
        else                           return stored;
    endfunction

    assign rd_a = rd_port(ra_a, we, wa, wd, regs[ra_a]);
    assign rd_b = rd_port(ra_b, we, wa, wd, regs[ra_b]);
endmodule

// File: rtl/fwd_hazard_ctl.sv
module fwd_hazard_ctl
    import hzd_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] id_rs_a,
    input  logic [AW-1:0] id_rs_b,
    input  logic          id_use_a,
    input  logic          id_use_b,
    input  logic [AW-1:0] ex_rs_a,
    input  logic [AW-1:0] ex_rs_b,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_is_load,
    input  logic [AW-1:0] xm_rd,
    input  logic          xm_we,
    input  logic          xm_load,
    input  logic [AW-1:0] mw_rd,
    input  logic          mw_we,
    input  logic [DW-1:0] mw_wdata,
    output logic [1:0]    fwd_sel_a,
    output logic [1:0]    fwd_sel_b,
    output logic          stall,
    output logic [DW-1:0] id_rdata_a,
    output logic [DW-1:0] id_rdata_b
);
    localparam int NOPS = 2;

    logic [AW-1:0] ex_src [NOPS];
    opsel_e        sel    [NOPS];

    assign ex_src[0] = ex_rs_a;
    assign ex_src[1] = ex_rs_b;

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        hzd_fwd_sel #(.AW(AW)) u_sel (
            .src    (ex_src[g]),
            .xm_rd  (xm_rd),
            .xm_we  (xm_we),
            .xm_load(xm_load),
            .mw_rd  (mw_rd),
            .mw_we  (mw_we),
            .sel    (sel[g])
        );
    end

    assign fwd_sel_a = sel[0];
    assign fwd_sel_b = sel[1];

    hzd_load_lock #(.AW(AW)) u_lock (
        .ex_is_load(ex_is_load),
        .ex_rd     (ex_rd),
        .id_rs_a   (id_rs_a),
        .id_rs_b   (id_rs_b),
        .id_use_a  (id_use_a),
        .id_use_b  (id_use_b),
        .stall     (stall)
    );

    hzd_regfile #(.AW(AW), .DW(DW)) u_rf (
        .clk (clk),
        .rst (rst),
        .we  (mw_we),
        .wa  (mw_rd),
        .wd  (mw_wdata),
        .ra_a(id_rs_a),
        .ra_b(id_rs_b),
        .rd_a(id_rdata_a),
        .rd_b(id_rdata_b)
    );
endmodule

// File: rtl/hzd_chk.sv
module hzd_chk #(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] id_rs_a,
    input logic [AW-1:0] id_rs_b,
    input logic          id_use_a,
    input logic          id_use_b,
    input logic [AW-1:0] ex_rs_a,
    input logic [AW-1:0] ex_rs_b,
    input logic [AW-1:0] ex_rd,
    input logic          ex_is_load,
    input logic [AW-1:0] xm_rd,
    input logic          xm_we,
    input logic          xm_load,
    input logic [AW-1:0] mw_rd,
    input logic          mw_we,
    input logic [DW-1:0] mw_wdata,
    input logic [1:0]    fwd_sel_a,
    input logic [1:0]    fwd_sel_b,
    input logic          stall,
    input logic [DW-1:0] id_rdata_a,
    input logic [DW-1:0] id_rdata_b
);
    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        fwd_sel_a != 2'b11 && fwd_sel_b != 2'b11); // R1
    AST_XM_FIRST: assert property (@(posedge clk) disable iff (rst)
        (ex_rs_a != '0 && xm_we && !xm_load && xm_rd == ex_rs_a && mw_we && mw_rd == ex_rs_a)
        |-> fwd_sel_a == 2'b10); // R3
    AST_MW_PATH: assert property (@(posedge clk) disable iff (rst)
        (ex_rs_b != '0 && mw_we && mw_rd == ex_rs_b && !(xm_we && xm_rd == ex_rs_b))
        |-> fwd_sel_b == 2'b01); // R2
    AST_ZERO_SRC: assert property (@(posedge clk) disable iff (rst)
        (ex_rs_a == '0) |-> fwd_sel_a == 2'b00); // R4
    AST_LOAD_NO_XM: assert property (@(posedge clk) disable iff (rst)
        xm_load |-> (fwd_sel_a != 2'b10 && fwd_sel_b != 2'b10)); // R5
    AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        stall |-> (ex_is_load && ex_rd != '0 && (id_use_a || id_use_b))); // R7
    AST_STALL_HIT: assert property (@(posedge clk) disable iff (rst)
        (ex_is_load && ex_rd != '0 && id_use_b && id_rs_b == ex_rd) |-> stall); // R6
    AST_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (mw_we && mw_rd != '0 && mw_rd == id_rs_a) |-> id_rdata_a == mw_wdata); // R8
    AST_R0_READ: assert property (@(posedge clk) disable iff (rst)
        (id_rs_b == '0) |-> id_rdata_b == '0); // R9
    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !mw_we) |-> (id_rdata_a == '0 && id_rdata_b == '0)); // R10
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(mw_we) && !mw_we && $stable(id_rs_a))
        |-> $stable(id_rdata_a)); // R11
endmodule

bind fwd_hazard_ctl hzd_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk(clk), .rst(rst),
    .id_rs_a(id_rs_a), .id_rs_b(id_rs_b), .id_use_a(id_use_a), .id_use_b(id_use_b),
    .ex_rs_a(ex_rs_a), .ex_rs_b(ex_rs_b), .ex_rd(ex_rd), .ex_is_load(ex_is_load),
    .xm_rd(xm_rd), .xm_we(xm_we), .xm_load(xm_load),
    .mw_rd(mw_rd), .mw_we(mw_we), .mw_wdata(mw_wdata),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .stall(stall),
    .id_rdata_a(id_rdata_a), .id_rdata_b(id_rdata_b)
);

// File: tb/fwd_hazard_ctl_tb_top.sv
`timescale 1ns/1ps
module fwd_hazard_ctl_tb_top;
    localparam int AW = 3;
    localparam int DW = 8;
    localparam int NR = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] id_rs_a = '0, id_rs_b = '0;
    logic          id_use_a = 1'b0, id_use_b = 1'b0;
    logic [AW-1:0] ex_rs_a = '0, ex_rs_b = '0, ex_rd = '0;
    logic          ex_is_load = 1'b0;
    logic [AW-1:0] xm_rd = '0;
    logic          xm_we = 1'b0, xm_load = 1'b0;
    logic [AW-1:0] mw_rd = '0;
    logic          mw_we = 1'b0;
    logic [DW-1:0] mw_wdata = '0;
    logic [1:0]    fwd_sel_a, fwd_sel_b;
    logic          stall;
    logic [DW-1:0] id_rdata_a, id_rdata_b;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fwd_hazard_ctl #(.AW(AW), .DW(DW)) dut_i (.*);

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_sel(int src, int xr, int xw, int xl, int mr, int mw);
        if (src == 0) return 0;
        if (xw != 0 && xl == 0 && xr == src) return 2;
        if (mw != 0 && mr == src) return 1;
        return 0;
    endfunction

    function automatic string sel_tag(int src, int e, int xr, int xw, int xl, int mr, int mw);
        if (src == 0) return "R4";
        if (xl != 0 && xw != 0 && xr == src) return "R5";
        if (e == 2 && mw != 0 && mr == src) return "R3";
        if (e == 2) return "R1";
        return "R2";
    endfunction

    function automatic logic [DW-1:0] val_of(int r);
        return DW'(r * 29 + 3);
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Writes attempted during reset must not survive (R10).
        mw_we = 1'b1; mw_rd = 3'd5; mw_wdata = 8'hEE;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; mw_we = 1'b0;
        for (int r = 0; r < NR; r++) begin
            id_rs_a = AW'(r); id_rs_b = AW'(r);
            #1;
            chk("R10 reset read a", int'(id_rdata_a), 0);
            chk("R10 reset read b", int'(id_rdata_b), 0);
            @(negedge clk);
        end

        // Same-cycle write bypass, then retention.
        for (int r = 1; r < NR; r++) begin
            mw_we = 1'b1; mw_rd = AW'(r); mw_wdata = val_of(r);
            id_rs_a = AW'(r); id_rs_b = AW'(r);
            #1;
            chk("R8 bypass a", int'(id_rdata_a), int'(val_of(r)));
            chk("R8 bypass b", int'(id_rdata_b), int'(val_of(r)));
            @(negedge clk);
            mw_we = 1'b0;
            #1;
            chk("R11 held after write", int'(id_rdata_b), int'(val_of(r)));
        end

        // Register 0 write is dropped.
        mw_we = 1'b1; mw_rd = '0; mw_wdata = 8'hAA; id_rs_a = '0;
        #1;
        chk("R9 r0 read during write", int'(id_rdata_a), 0);
        @(negedge clk);
        mw_we = 1'b0;
        #1;
        chk("R9 r0 read after write", int'(id_rdata_a), 0);

        // Disabled write leaves the register alone.
        mw_we = 1'b0; mw_rd = 3'd3; mw_wdata = 8'hFF; id_rs_a = 3'd4;
        @(negedge clk);
        @(negedge clk);
        id_rs_a = 3'd3;
        #1;
        chk("R11 we low ignored", int'(id_rdata_a), int'(val_of(3)));
        for (int r = 1; r < NR; r++) begin
            id_rs_b = AW'(r);
            #1;
            chk("R11 all retained", int'(id_rdata_b), int'(val_of(r)));
        end

        // Forwarding sweep over every source and buffer combination.
        for (int s = 0; s < NR; s++)
            for (int xr = 0; xr < NR; xr++)
                for (int mr = 0; mr < NR; mr++)
                    for (int f = 0; f < 8; f++) begin
                        int xw = f & 1;
                        int xl = (f >> 1) & 1;
                        int mw = (f >> 2) & 1;
                        int sb = (s + 3) % NR;
                        int ea = exp_sel(s, xr, xw, xl, mr, mw);
                        int eb = exp_sel(sb, xr, xw, xl, mr, mw);
                        @(negedge clk);
                        ex_rs_a = AW'(s); ex_rs_b = AW'(sb);
                        xm_rd = AW'(xr); xm_we = xw[0]; xm_load = xl[0];
                        mw_rd = AW'(mr); mw_we = mw[0]; mw_wdata = val_of(mr);
                        #1;
                        chk(sel_tag(s, ea, xr, xw, xl, mr, mw), int'(fwd_sel_a), ea);
                        chk(sel_tag(sb, eb, xr, xw, xl, mr, mw), int'(fwd_sel_b), eb);
                    end
        @(negedge clk);
        mw_we = 1'b0; xm_we = 1'b0; xm_load = 1'b0;

        // Load-use interlock sweep.
        for (int d = 0; d < NR; d++)
            for (int a = 0; a < NR; a++)
                for (int b = 0; b < NR; b++)
                    for (int f = 0; f < 8; f++) begin
                        int ua = f & 1;
                        int ub = (f >> 1) & 1;
                        int ld = (f >> 2) & 1;
                        int es = (ld != 0 && d != 0 &&
                                  ((ua != 0 && a == d) || (ub != 0 && b == d))) ? 1 : 0;
                        @(negedge clk);
                        ex_rd = AW'(d); ex_is_load = ld[0];
                        id_rs_a = AW'(a); id_rs_b = AW'(b);
                        id_use_a = ua[0]; id_use_b = ub[0];
                        #1;
                        chk(es != 0 ? "R6 stall" : "R7 no stall", int'(stall), es);
                    end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule